// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox

This block gives two ports that run on unrelated clocks a way to pass single words to each other outside a bulk data path. One mailbox carries a word from port A to port B. The other carries a word from port B to port A. Each port has a select input. When the select is high, that port's write or read strobe goes to the mailbox. When the select is low, the strobe is left for other logic, such as a FIFO, and the mailbox ignores it.

Every mailbox has a full flag in the writer's clock domain and a ready flag in the reader's clock domain. A write that is accepted stores the word and raises the writer's flag. The event crosses to the reader's domain as a toggle through a two-flop synchronizer, and there it raises the ready flag. When the reader reads the word, a second toggle goes back to the writer and clears the full flag. While the full flag is set, the stored word cannot change. The reader can therefore sample it at any time while ready is high.

Top module: `dual_mailbox`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, all four flags are low: `ab_full`, `ab_ready`, `ba_full` and `ba_ready`.
- R2: A write accepted on port A (`a_sel`=1, `a_wr`=1 and `ab_full`=0) raises `ab_full` at that clk_a edge. A write on port A with `a_sel`=0 leaves `ab_full` low.
- R3: A write on port A while `ab_full` is high is ignored. The word port B later reads is the first word, not the second.
- R4: After an accepted port-A write, `ab_ready` rises within 4 clk_b cycles, and `b_rdata` then equals the written word.
- R5: A read on port B with `b_sel`=1, `b_rd`=1 and `ab_ready`=1 drops `ab_ready` at that clk_b edge. `ab_full` then falls within 5 clk_a cycles, and after that the mailbox accepts a new write.
- R6: A read on port B while `ab_ready` is low, or with `b_sel`=0, is ignored. It does not drop a pending ready flag, and it does not disturb the next transfer.
- R7: The port-B-to-port-A mailbox follows R2 to R6 with the ports swapped. Its signals are `b_sel`, `b_wr`, `ba_full`, `ba_ready` and `a_rdata`.
- R8: Both mailboxes can hold mail at the same time without affecting each other's data or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_sel | input | 1 | Port A mailbox select |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_wdata | input | W | Word written into the A-to-B mailbox |
| a_rdata | output | W | Contents of the B-to-A mailbox |
| ab_full | output | 1 | A-to-B mailbox holds unread mail (clk_a domain) |
| ba_ready | output | 1 | B-to-A mail waiting for port A (clk_a domain) |
| b_sel | input | 1 | Port B mailbox select |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_wdata | input | W | Word written into the B-to-A mailbox |
| b_rdata | output | W | Contents of the A-to-B mailbox |
| ba_full | output | 1 | B-to-A mailbox holds unread mail (clk_b domain) |
| ab_ready | output | 1 | A-to-B mail waiting for port B (clk_b domain) |

## Verification
A table of words is sent in alternating directions. It includes all-zeros, all-ones and alternating bit patterns, so a stuck or swapped data bit shows up in the received word.

Directed cases follow the table:
- A second write to a full mailbox tells a blocked overwrite apart from a lost one.
- Reads with the select low, or with no mail waiting, show whether the toggle handshake can be corrupted.
- Strobes with the select low show that the mailbox honours the steering.
- One transfer in each direction, both in flight together, separates the two handshakes.

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
  parameter int W = 36
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_sel,
  input  logic         a_wr,
  input  logic         a_rd,
  input  logic [W-1:0] a_wdata,
  output logic [W-1:0] a_rdata,
  output logic         ab_full,
  output logic         ba_ready,
  input  logic         b_sel,
  input  logic         b_wr,
  input  logic         b_rd,
  input  logic [W-1:0] b_wdata,
  output logic [W-1:0] b_rdata,
  output logic         ba_full,
  output logic         ab_ready
);

  logic [W-1:0] ab_word, ba_word;
  logic ab_wtog, ab_rtog, ba_wtog, ba_rtog;
  logic [1:0] ab_wsync, ab_rsync, ba_wsync, ba_rsync;

  assign ab_full  = ab_wtog != ab_rsync[1];
  assign ab_ready = ab_wsync[1] != ab_rtog;
  assign ba_full  = ba_wtog != ba_rsync[1];
  assign ba_ready = ba_wsync[1] != ba_rtog;
  assign b_rdata  = ab_word;
  assign a_rdata  = ba_word;

  wire ab_put = a_sel && a_wr && !ab_full;
  wire ab_get = b_sel && b_rd && ab_ready;
  wire ba_put = b_sel && b_wr && !ba_full;
  wire ba_get = a_sel && a_rd && ba_ready;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) begin
      ab_word  <= '0;
      ab_wtog  <= 1'b0;
      ba_rtog  <= 1'b0;
      ab_rsync <= '0;
      ba_wsync <= '0;
    end else begin
      if (ab_put) begin
        ab_word <= a_wdata;
        ab_wtog <= ~ab_wtog;
      end
      if (ba_get) ba_rtog <= ~ba_rtog;
      ab_rsync <= {ab_rsync[0], ab_rtog};
      ba_wsync <= {ba_wsync[0], ba_wtog};
    end

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) begin
      ba_word  <= '0;
      ba_wtog  <= 1'b0;
      ab_rtog  <= 1'b0;
      ba_rsync <= '0;
      ab_wsync <= '0;
    end else begin
      if (ba_put) begin
        ba_word <= b_wdata;
        ba_wtog <= ~ba_wtog;
      end
      if (ab_get) ab_rtog <= ~ab_rtog;
      ba_rsync <= {ba_rsync[0], ba_rtog};
      ab_wsync <= {ab_wsync[0], ab_wtog};
    end

  assert_ab_set_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_sel && a_wr && !ab_full) |=> ab_full);
  assert_ab_hold_R3: assert property (@(posedge clk_a) disable iff (!rst_n)
    ab_full |=> $stable(b_rdata));
  assert_ab_clear_R5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_sel && b_rd && ab_ready) |=> !ab_ready);
  assert_ba_set_R7: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_sel && b_wr && !ba_full) |=> ba_full);
  assert_ba_hold_R7: assert property (@(posedge clk_b) disable iff (!rst_n)
    ba_full |=> $stable(a_rdata));
  assert_ba_clear_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_sel && a_rd && ba_ready) |=> !ba_ready);

endmodule

// File: tb/dual_mailbox_bench.sv
module dual_mailbox_bench;
  localparam int W = 36;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_sel = 0, a_wr = 0, a_rd = 0, b_sel = 0, b_wr = 0, b_rd = 0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rdata, b_rdata;
  logic ab_full, ab_ready, ba_full, ba_ready;
  int errors = 0, checks = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  dual_mailbox #(.W(W)) u_dual_mailbox (.*);

  // bit 36: direction (0 = A to B, 1 = B to A)
  localparam logic [W:0] VEC [0:5] = '{
    {1'b0, 36'h000000000}, {1'b1, 36'hFFFFFFFFF}, {1'b0, 36'hAAAAAAAAA},
    {1'b1, 36'h555555555}, {1'b0, 36'h123456789}, {1'b1, 36'h800000001}};

  task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_ab(input logic [W-1:0] w);
    @(negedge clk_a); a_sel = 1; a_wr = 1; a_wdata = w;
    @(negedge clk_a); a_sel = 0; a_wr = 0;
    check(ab_full, "R2 ab_full after write", W'(ab_full), 1);
  endtask

  task automatic recv_ab(input logic [W-1:0] w);
    int n = 0;
    while (!ab_ready && n < 6) begin @(negedge clk_b); n++; end
    check(ab_ready && n <= 4, "R4 ab_ready latency", W'(n), 4);
    check(b_rdata == w, "R4 b_rdata word", b_rdata, w);
    @(negedge clk_b); b_sel = 1; b_rd = 1;
    @(negedge clk_b); b_sel = 0; b_rd = 0;
    check(!ab_ready, "R5 ab_ready cleared by read", W'(ab_ready), 0);
    n = 0;
    while (ab_full && n < 7) begin @(negedge clk_a); n++; end
    check(!ab_full && n <= 5, "R5 ab_full clears", W'(n), 5);
  endtask

  task automatic send_ba(input logic [W-1:0] w);
    @(negedge clk_b); b_sel = 1; b_wr = 1; b_wdata = w;
    @(negedge clk_b); b_sel = 0; b_wr = 0;
    check(ba_full, "R7 ba_full after write", W'(ba_full), 1);
  endtask

  task automatic recv_ba(input logic [W-1:0] w);
    int n = 0;
    while (!ba_ready && n < 6) begin @(negedge clk_a); n++; end
    check(ba_ready && n <= 4, "R7 ba_ready latency", W'(n), 4);
    check(a_rdata == w, "R7 a_rdata word", a_rdata, w);
    @(negedge clk_a); a_sel = 1; a_rd = 1;
    @(negedge clk_a); a_sel = 0; a_rd = 0;
    check(!ba_ready, "R7 ba_ready cleared by read", W'(ba_ready), 0);
    n = 0;
    while (ba_full && n < 7) begin @(negedge clk_b); n++; end
    check(!ba_full && n <= 5, "R7 ba_full clears", W'(n), 5);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #12;
    check({ab_full, ab_ready, ba_full, ba_ready} == 4'b0, "R1 flags in reset",
          W'({ab_full, ab_ready, ba_full, ba_ready}), 0);
    @(negedge clk_a); rst_n = 1;
    @(negedge clk_b);
    check({ab_full, ab_ready, ba_full, ba_ready} == 4'b0, "R1 flags after reset",
          W'({ab_full, ab_ready, ba_full, ba_ready}), 0);

    for (int i = 0; i < 6; i++) begin
      if (!VEC[i][W]) begin send_ab(VEC[i][W-1:0]); recv_ab(VEC[i][W-1:0]); end
      else begin send_ba(VEC[i][W-1:0]); recv_ba(VEC[i][W-1:0]); end
    end

    // R2: write without select ignored
    @(negedge clk_a); a_wr = 1; a_wdata = 36'hDEADBEEF0;
    @(negedge clk_a); a_wr = 0;
    repeat (6) @(negedge clk_b);
    check(!ab_full && !ab_ready, "R2 unselected write ignored", W'({ab_full, ab_ready}), 0);

    // R6: read with no mail waiting, then normal transfer
    @(negedge clk_b); b_sel = 1; b_rd = 1;
    @(negedge clk_b); b_sel = 0; b_rd = 0;
    repeat (4) @(negedge clk_a);
    check(!ab_ready && !ab_full, "R6 empty read ignored", W'({ab_full, ab_ready}), 0);

    // R3: overwrite blocked
    send_ab(36'h0CAFEF00D);
    @(negedge clk_a); a_sel = 1; a_wr = 1; a_wdata = 36'h111111111;
    @(negedge clk_a); a_sel = 0; a_wr = 0;
    repeat (6) @(negedge clk_b);
    check(b_rdata == 36'h0CAFEF00D, "R3 overwrite blocked", b_rdata, 36'h0CAFEF00D);

    // R6: read without select keeps ready
    @(negedge clk_b); b_rd = 1;
    @(negedge clk_b); b_rd = 0;
    check(ab_ready, "R6 unselected read ignored", W'(ab_ready), 1);
    recv_ab(36'h0CAFEF00D);

    // R8: both directions in flight together
    send_ab(36'hA5A5A5A5A);
    send_ba(36'h5A5A5A5A5);
    repeat (6) @(negedge clk_a);
    check(ab_full && ba_full && ab_ready && ba_ready, "R8 both pending",
          W'({ab_full, ba_full, ab_ready, ba_ready}), 4'hF);
    recv_ba(36'h5A5A5A5A5);
    check(ab_ready && b_rdata == 36'hA5A5A5A5A, "R8 A-to-B undisturbed", b_rdata, 36'hA5A5A5A5A);
    recv_ab(36'hA5A5A5A5A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule